// File: doc/BRIEF.md
# Dual-Bank Tightly Coupled RAM Arbiter

This block sits between three masters and a 16 KB on-chip RAM built as two 8 KB physical banks. The masters are an instruction-fetch port, a data port and an external DMA port. The instruction port addresses the RAM through the window 0x0000–0x7FFF. The data and DMA ports address it through the window 0x8000–0xFFFF. Both windows alias onto the same storage. Every request is decoded to a bank. In each cycle each bank is granted to one requester, so two requests that target different banks both proceed in the same cycle.

When two or three requests target the same bank, a fixed priority decides the winner: data first, then instruction, then DMA. A small ageing state machine protects DMA from starvation. It has three states. AGE_IDLE means no DMA request is waiting. AGE_WAIT counts consecutive cycles in which DMA lost. AGE_BOOST makes DMA the top priority on both banks. The transitions are as follows. AGE_IDLE moves to AGE_WAIT on a DMA loss, or straight to AGE_BOOST when the loss limit is 1. AGE_WAIT moves to AGE_BOOST on the loss that reaches the limit. AGE_WAIT and AGE_BOOST both return to AGE_IDLE when DMA is granted or drops its request. A losing port sees ready low and keeps its request stable until granted. A write lands in the grant cycle. Read data is presented on the port one cycle after the grant. A request outside its port's window is never sent to the RAM. It completes at once with an error flag.

The RAM banks are outside the block: each bank has an enable, a write enable, a word address and write data, and returns read data one cycle after the enable.

Top module: `tcm_arbiter`

## Requirements
- R1: A request whose address lies outside its port's window is answered in the same cycle with ready=1 and err=1, and no bank is enabled on its behalf. The instruction window has address bit 15 = 0. The data and DMA windows have address bit 15 = 1.
- R2: Inside a window, address bits [13:0] are the RAM offset and bit 14 is ignored. Bit 13 selects the bank, and bits [12:2] are the 32-bit word address within that bank. An instruction address A and the data address 0x8000|A therefore reach the same word.
- R3: Requests that target different banks are all granted (ready=1) in the same cycle.
- R4: On a same-bank conflict, data wins over instruction and instruction wins over DMA. Only the winner sees ready=1.
- R5: A losing port that holds its request sees ready=0 until its bank is free, and is then granted.
- R6: A DMA request that has lost for 4 consecutive cycles is granted in the next cycle, even over the data port.
- R7: A write is stored in its grant cycle. A granted read returns the stored word on the port's read data one cycle later.
- R8: During and after reset, with no requests, every ready, every err and every bank enable is 0.
- R9: Each bank is granted to at most one port per cycle, and only to a port that requests it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_req | input | 1 | Instruction port request |
| i_addr | input | 16 | Instruction port byte address |
| i_we | input | 1 | Instruction port write enable |
| i_wdata | input | 32 | Instruction port write data |
| i_rdata | output | 32 | Instruction port read data, valid one cycle after a read grant |
| i_ready | output | 1 | Instruction port accepted this cycle |
| i_err | output | 1 | Instruction port address outside its window |
| d_req | input | 1 | Data port request |
| d_addr | input | 16 | Data port byte address |
| d_we | input | 1 | Data port write enable |
| d_wdata | input | 32 | Data port write data |
| d_rdata | output | 32 | Data port read data |
| d_ready | output | 1 | Data port accepted this cycle |
| d_err | output | 1 | Data port address outside its window |
| m_req | input | 1 | DMA port request |
| m_addr | input | 16 | DMA port byte address |
| m_we | input | 1 | DMA port write enable |
| m_wdata | input | 32 | DMA port write data |
| m_rdata | output | 32 | DMA port read data |
| m_ready | output | 1 | DMA port accepted this cycle |
| m_err | output | 1 | DMA port address outside its window |
| bk_en | output | 2 | Per-bank access enable |
| bk_we | output | 2 | Per-bank write enable |
| bk_addr | output | 22 | Per-bank word address, 11 bits per bank |
| bk_wdata | output | 64 | Per-bank write data, 32 bits per bank |
| bk_rdata | input | 64 | Per-bank read data, 32 bits per bank, one cycle after enable |

## Verification
Two grants can fall in the same cycle, one on each bank. The bench provokes this by sweeping every subset of the three ports against every bank assignment in one-cycle bursts. For each burst it predicts from the priority order which ports see ready, and only pairs split across banks may both pass. The DMA promotion is also checked to land in the same cycle as a data request that it must override.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;
    localparam int P_INST = 0;
    localparam int P_DATA = 1;
    localparam int P_DMA  = 2;
    localparam int NPORT  = 3;

    typedef enum logic [1:0] {
        AGE_IDLE  = 2'd0,
        AGE_WAIT  = 2'd1,
        AGE_BOOST = 2'd2
    } age_state_e;
endpackage

// File: rtl/tcm_win_decode.sv
module tcm_win_decode #(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG  = 15,
    parameter int OFF_W    = 14,
    parameter int BYTE_LSB = 2,
    parameter int WIN_TAG  = 0
) (
    input  logic                          req,
    input  logic [ADDR_W-1:0]             addr,
    output logic                          hit,
    output logic                          miss,
    output logic                          bank,
    output logic [OFF_W-2-BYTE_LSB:0]     word
);
    localparam int TAG_W = ADDR_W - WIN_LOG;

    logic in_win;

    assign in_win = (addr[ADDR_W-1:WIN_LOG] == TAG_W'(WIN_TAG));
    assign hit    = req && in_win;
    assign miss   = req && !in_win;
    assign bank   = addr[OFF_W-1];
    assign word   = addr[OFF_W-2:BYTE_LSB];
endmodule

// File: rtl/tcm_bank_arb.sv
module tcm_bank_arb
    import tcm_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] want,
    input  logic             boost,
    output logic [NPORT-1:0] grant
);
    always_comb begin
        grant = '0;
        if (boost && want[P_DMA])
            grant[P_DMA] = 1'b1;
        else if (want[P_DATA])
            grant[P_DATA] = 1'b1;
        else if (want[P_INST])
            grant[P_INST] = 1'b1;
        else if (want[P_DMA])
            grant[P_DMA] = 1'b1;
    end

    assert_one_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~want) == '0));

    assert_no_idle_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (want != '0) |-> (grant != '0));

    assert_data_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (want[P_DATA] && !boost) |-> grant[P_DATA]);
endmodule

// File: rtl/tcm_dma_age.sv
module tcm_dma_age
    import tcm_arb_pkg::*;
#(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic won,
    output logic boost
);
    localparam int CNT_W = $clog2(LIMIT + 2);

    age_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= AGE_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            AGE_IDLE: begin
                if (pend && !won) begin
                    if (LIMIT <= 1) begin
                        st_n = AGE_BOOST;
                    end else begin
                        st_n  = AGE_WAIT;
                        cnt_n = CNT_W'(1);
                    end
                end
            end
            AGE_WAIT: begin
                if (!pend || won) begin
                    st_n  = AGE_IDLE;
                    cnt_n = '0;
                end else if (cnt_q == CNT_W'(LIMIT - 1)) begin
                    st_n  = AGE_BOOST;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            AGE_BOOST: begin
                if (!pend || won)
                    st_n = AGE_IDLE;
            end
            default: begin
                st_n  = AGE_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    always_comb begin
        boost = (st_q == AGE_BOOST);
    end

    // Independent run-length of DMA losses, used only by the check below.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (pend && !won && run_q < CNT_W'(LIMIT))
            run_q <= run_q + CNT_W'(1);
        else if (!(pend && !won))
            run_q <= '0;
    end

    assert_promote_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && run_q >= CNT_W'(LIMIT)) |-> won);
endmodule

// File: rtl/tcm_arbiter.sv
module tcm_arbiter
    import tcm_arb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int WIN_LOG      = 15,
    parameter int OFF_W        = 14,
    parameter int STARVE_LIMIT = 4,
    localparam int NB          = 2,
    localparam int BYTE_LSB    = $clog2(DATA_W / 8),
    localparam int BANK_AW     = OFF_W - 1 - BYTE_LSB
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_req,
    input  logic [ADDR_W-1:0]     i_addr,
    input  logic                  i_we,
    input  logic [DATA_W-1:0]     i_wdata,
    output logic [DATA_W-1:0]     i_rdata,
    output logic                  i_ready,
    output logic                  i_err,
    input  logic                  d_req,
    input  logic [ADDR_W-1:0]     d_addr,
    input  logic                  d_we,
    input  logic [DATA_W-1:0]     d_wdata,
    output logic [DATA_W-1:0]     d_rdata,
    output logic                  d_ready,
    output logic                  d_err,
    input  logic                  m_req,
    input  logic [ADDR_W-1:0]     m_addr,
    input  logic                  m_we,
    input  logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W-1:0]     m_rdata,
    output logic                  m_ready,
    output logic                  m_err,
    output logic [NB-1:0]         bk_en,
    output logic [NB-1:0]         bk_we,
    output logic [NB*BANK_AW-1:0] bk_addr,
    output logic [NB*DATA_W-1:0]  bk_wdata,
    input  logic [NB*DATA_W-1:0]  bk_rdata
);
    logic [NPORT-1:0]                req_v, we_v, hit, miss, bank_v, gnt_port, rd_bank_q;
    logic [NPORT-1:0][ADDR_W-1:0]    addr_v;
    logic [NPORT-1:0][DATA_W-1:0]    wdata_v, rdata_v;
    logic [NPORT-1:0][BANK_AW-1:0]   word_v;
    logic [NB-1:0][NPORT-1:0]        want, grant;
    logic                            dma_boost;

    assign req_v   = {m_req, d_req, i_req};
    assign we_v    = {m_we, d_we, i_we};
    assign addr_v  = {m_addr, d_addr, i_addr};
    assign wdata_v = {m_wdata, d_wdata, i_wdata};

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        tcm_win_decode #(
            .ADDR_W  (ADDR_W),
            .WIN_LOG (WIN_LOG),
            .OFF_W   (OFF_W),
            .BYTE_LSB(BYTE_LSB),
            .WIN_TAG ((p == P_INST) ? 0 : 1)
        ) u_dec (
            .req (req_v[p]),
            .addr(addr_v[p]),
            .hit (hit[p]),
            .miss(miss[p]),
            .bank(bank_v[p]),
            .word(word_v[p])
        );
    end

    always_comb begin
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NPORT; p++)
                want[b][p] = hit[p] && (int'(bank_v[p]) == b);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        tcm_bank_arb u_arb (
            .clk  (clk),
            .rst_n(rst_n),
            .want (want[b]),
            .boost(dma_boost),
            .grant(grant[b])
        );
    end

    always_comb begin
        gnt_port = '0;
        bk_en    = '0;
        bk_we    = '0;
        bk_addr  = '0;
        bk_wdata = '0;
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (grant[b][p]) begin
                    gnt_port[p]                      = 1'b1;
                    bk_en[b]                         = 1'b1;
                    bk_we[b]                         = we_v[p];
                    bk_addr[b*BANK_AW +: BANK_AW]    = word_v[p];
                    bk_wdata[b*DATA_W +: DATA_W]     = wdata_v[p];
                end
            end
        end
    end

    tcm_dma_age #(.LIMIT(STARVE_LIMIT)) u_age (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (hit[P_DMA]),
        .won  (gnt_port[P_DMA]),
        .boost(dma_boost)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bank_q <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++)
                if (gnt_port[p] && !we_v[p])
                    rd_bank_q[p] <= bank_v[p];
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++)
            rdata_v[p] = bk_rdata[int'(rd_bank_q[p]) * DATA_W +: DATA_W];
    end

    assign i_rdata = rdata_v[P_INST];
    assign d_rdata = rdata_v[P_DATA];
    assign m_rdata = rdata_v[P_DMA];
    assign i_ready = miss[P_INST] | gnt_port[P_INST];
    assign d_ready = miss[P_DATA] | gnt_port[P_DATA];
    assign m_ready = miss[P_DMA]  | gnt_port[P_DMA];
    assign i_err   = miss[P_INST];
    assign d_err   = miss[P_DATA];
    assign m_err   = miss[P_DMA];

    assert_err_no_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (i_err || d_err || m_err) |-> ((i_ready || !i_err) && (d_ready || !d_err)
                                       && (m_ready || !m_err)
                                       && $countones(bk_en) <= NPORT - 1));

    assert_split_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_req && d_req && !i_addr[WIN_LOG] && d_addr[WIN_LOG]
         && (i_addr[OFF_W-1] != d_addr[OFF_W-1])) |-> (i_ready && d_ready));

    assert_we_with_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bk_we & ~bk_en) == '0));

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!i_req && !d_req && !m_req) |-> (bk_en == '0 && !i_ready && !d_ready && !m_ready));
endmodule

// File: tb/tcm_arbiter_tb.sv
module tcm_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_req, d_req, m_req, i_we, d_we, m_we;
    logic [15:0] i_addr, d_addr, m_addr;
    logic [31:0] i_wdata, d_wdata, m_wdata, i_rdata, d_rdata, m_rdata;
    logic        i_ready, d_ready, m_ready, i_err, d_err, m_err;
    logic [1:0]  bk_en, bk_we;
    logic [21:0] bk_addr;
    logic [63:0] bk_wdata;
    logic [63:0] bk_rdata = '0;
    logic [31:0] bmem [int];
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    tcm_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .i_req(i_req), .i_addr(i_addr), .i_we(i_we), .i_wdata(i_wdata),
        .i_rdata(i_rdata), .i_ready(i_ready), .i_err(i_err),
        .d_req(d_req), .d_addr(d_addr), .d_we(d_we), .d_wdata(d_wdata),
        .d_rdata(d_rdata), .d_ready(d_ready), .d_err(d_err),
        .m_req(m_req), .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
        .bk_en(bk_en), .bk_we(bk_we), .bk_addr(bk_addr),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    // Bank storage model: one-cycle read latency, sparse.
    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (bk_en[b]) begin
                int key;
                key = b * 4096 + int'(bk_addr[b*11 +: 11]);
                if (bk_we[b])
                    bmem[key] = bk_wdata[b*32 +: 32];
                else
                    bk_rdata[b*32 +: 32] <= bmem.exists(key) ? bmem[key] : 32'h0;
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic idle_all();
        i_req = 0; d_req = 0; m_req = 0;
        i_we = 0; d_we = 0; m_we = 0;
        i_addr = '0; d_addr = '0; m_addr = '0;
        i_wdata = '0; d_wdata = '0; m_wdata = '0;
    endtask

    task automatic drive(input int p, input logic [15:0] a, input bit we, input logic [31:0] wd);
        case (p)
            0: begin i_req = 1; i_addr = a; i_we = we; i_wdata = wd; end
            1: begin d_req = 1; d_addr = a; d_we = we; d_wdata = wd; end
            default: begin m_req = 1; m_addr = a; m_we = we; m_wdata = wd; end
        endcase
    endtask

    function automatic logic rdy(input int p);
        return (p == 0) ? i_ready : (p == 1) ? d_ready : m_ready;
    endfunction

    function automatic logic [31:0] rdat(input int p);
        return (p == 0) ? i_rdata : (p == 1) ? d_rdata : m_rdata;
    endfunction

    task automatic acc(input int p, input logic [15:0] a, input bit we,
                       input logic [31:0] wd, input logic [31:0] exp, input string rq);
        @(negedge clk);
        idle_all();
        drive(p, a, we, wd);
        #1 chk({rq, " ready"}, 32'(rdy(p)), 32'h1);
        @(negedge clk);
        idle_all();
        #1 if (!we) chk({rq, " rdata"}, rdat(p), exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        idle_all();
        @(negedge clk);
        #1;
        // R8: quiet outputs while held in reset
        chk("R8 reset readies", 32'({i_ready, d_ready, m_ready}), 32'h0);
        chk("R8 reset bank enables", 32'(bk_en), 32'h0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk("R8 idle readies and errs", 32'({i_ready, d_ready, m_ready, i_err, d_err, m_err}), 32'h0);

        // R1: out-of-window requests
        @(negedge clk); idle_all(); drive(0, 16'h8010, 0, 0);
        #1 chk("R1 inst out of window", 32'({i_ready, i_err, bk_en}), 32'b1100);
        @(negedge clk); idle_all(); drive(1, 16'h0040, 1, 32'hDEAD);
        #1 chk("R1 data out of window", 32'({d_ready, d_err, bk_en}), 32'b1100);
        @(negedge clk); idle_all(); drive(2, 16'h7FFC, 0, 0);
        #1 chk("R1 dma out of window", 32'({m_ready, m_err, bk_en}), 32'b1100);

        // R2 / R7: aliasing between windows, bit 14 ignored
        for (int k = 0; k < 24; k++) begin
            logic [15:0] off;
            logic [31:0] d1;
            off = 16'((k * 1237 + k * k * 29) & 16'h3FFC);
            d1  = 32'h1000_0000 + 32'(k) * 32'h0101_0101;
            acc(0, off, 1, d1, 0, "R7 inst write");
            acc(1, 16'h8000 | off, 0, 0, d1, "R2 data alias read");
            acc(1, 16'h8000 | off, 1, ~d1, 0, "R7 data write");
            acc(2, 16'hC000 | off, 0, 0, ~d1, "R2 dma read bit14 alias");
            acc(0, 16'h4000 | off, 0, 0, ~d1, "R2 inst read bit14 alias");
        end

        // R3 / R4: every port subset against every bank assignment
        for (int mask = 1; mask < 8; mask++) begin
            for (int bm = 0; bm < 8; bm++) begin
                logic [2:0] exp_r;
                logic [1:0] exp_en;
                @(negedge clk);
                idle_all();
                for (int p = 0; p < 3; p++)
                    if (mask[p])
                        drive(p, ((p == 0) ? 16'h0000 : 16'h8000) | (16'(bm[p]) << 13)
                                 | 16'(p * 4), 0, 0);
                exp_r = '0;
                exp_en = '0;
                for (int b = 0; b < 2; b++) begin
                    if (mask[1] && bm[1] == b[0]) exp_r[1] = 1;
                    else if (mask[0] && bm[0] == b[0]) exp_r[0] = 1;
                    else if (mask[2] && bm[2] == b[0]) exp_r[2] = 1;
                    exp_en[b] = (mask[0] && bm[0] == b[0]) || (mask[1] && bm[1] == b[0])
                                || (mask[2] && bm[2] == b[0]);
                end
                #1;
                chk($sformatf("R3 R4 readies mask=%0d banks=%0d", mask, bm),
                    32'({m_ready, d_ready, i_ready}), 32'(exp_r));
                chk($sformatf("R9 bank enables mask=%0d banks=%0d", mask, bm),
                    32'(bk_en), 32'(exp_en));
                @(negedge clk);
                idle_all();
            end
        end

        // R5: held loser waits, then proceeds
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            idle_all();
            drive(0, 16'h2010, 0, 0);
            if (c < 3) drive(1, 16'hA000 + 16'(c * 4), 0, 0);
            #1;
            if (c < 3) chk("R5 loser stalled", 32'({i_ready, d_ready}), 32'b01);
            else       chk("R5 loser proceeds", 32'(i_ready), 32'h1);
        end
        @(negedge clk); idle_all();

        // R6: DMA promotion after four losses
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            idle_all();
            drive(1, 16'h8000 + 16'(c * 4), 0, 0);
            if (c < 5) drive(2, 16'h8100, 0, 0);
            #1;
            if (c < 4)       chk("R6 dma loses", 32'({m_ready, d_ready}), 32'b01);
            else if (c == 4) chk("R6 dma promoted", 32'({m_ready, d_ready}), 32'b10);
            else             chk("R6 data resumes", 32'(d_ready), 32'h1);
        end
        @(negedge clk); idle_all();
        @(negedge clk);

        summary();
        $finish;
    end
endmodule